// File: doc/BRIEF.md
# Quarter-Rate Watchdog Timer

This block is a software-serviced watchdog. A down-counter is clocked by an enable that fires once every four peripheral clock cycles. Software programs a reload constant. It then turns the watchdog on through a mode register and starts or restarts the count by writing a two-byte service sequence to a service register. Firmware that stops servicing the counter lets it run down to zero. At zero the block either raises a level interrupt or sends a single-cycle reset request to the reset network, depending on a mode bit.

All accesses use one write port and one combinational read port, each addressed by a 2-bit register select. The select codes are: 0 = mode, 1 = reload constant, 2 = service, 3 = live counter value. The counter value can only be read, and a write to select 3 is ignored. Mode bits are: bit 0 = enable, bit 1 = reset-on-expiry, bit 2 = expiry flag. Writing 1 to bit 2 clears the flag. The service register always reads as 0.

Top module: `tick_watchdog`

## Requirements
- R1: After reset the counter reads 0xFF, the reload constant reads 0xFF, the mode register reads 0, and both `irq` and `rst_req` are low.
- R2: A reload-constant write (select 1) stores the written value, except that a value below 0xFF is stored as 0xFF.
- R3: A valid service sequence while the enable bit (mode bit 0) is 0 has no effect. The counter keeps its value and does not count.
- R4: While enabled, a valid service sequence loads the counter from the reload constant and restarts the quarter-rate prescaler. The counter then drops by exactly one on every fourth clock edge after the loading edge.
- R5: A valid service sequence is a service write with low byte 0xAA followed by the next service write with low byte 0x55. Any other service write between them breaks the sequence, and a broken sequence does not reload the counter.
- R6: Once the first valid service sequence has started the counter, writing 0 to the enable bit leaves it at 1.
- R7: When the counter steps from 1 to 0, the expiry flag (mode bit 2) is set and stays set. The counter then holds at 0 until the next valid service sequence. With reset-on-expiry off, `irq` follows the flag and `rst_req` stays low.
- R8: With reset-on-expiry (mode bit 1) on, expiry drives `rst_req` high for exactly one cycle, in the cycle after the fourth-cycle edge that brings the counter to 0. `irq` stays low.
- R9: A mode write with bit 2 set clears the expiry flag and so drops `irq`.
- R10: A new reload constant has no effect on the running count until the next valid service sequence, which then loads the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_sel | input | 2 | Write register select |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 32 | Read data for `rd_sel` (combinational) |
| irq | output | 1 | Expiry interrupt, level, when reset-on-expiry is off |
| rst_req | output | 1 | One-cycle reset request on expiry when reset-on-expiry is on |

## Verification
The bench tests the service handshake where it is most likely to fail. An 0xAA–other–0x55 sequence must not reload, and a bare 0x55 must not reload either; a design that only remembers "0xAA was seen at some point" would reload on both. It checks the counter at the edges just before and just after the fourth cycle following a service, so a prescaler that is not restarted on service, or that ticks one cycle early, shows up as an off-by-one value. At expiry it confirms that the counter holds at 0 instead of wrapping to all-ones. In reset mode it requires exactly one `rst_req` cycle at the predicted edge; a level output, or a request that repeats every tick, would give a count above one.

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
  parameter int CW      = 32,
  parameter int PRE_DIV = 4,
  parameter int TC_MIN  = 'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [31:0]   wr_data,
  input  logic [1:0]    rd_sel,
  output logic [31:0]   rd_data,
  output logic          irq,
  output logic          rst_req
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);
  localparam logic [CW-1:0] TC_FLOOR = CW'(TC_MIN);
  localparam logic [1:0] SEL_MODE = 2'd0, SEL_TC = 2'd1, SEL_FEED = 2'd2, SEL_CNT = 2'd3;

  logic [CW-1:0] cnt, tc;
  logic [PW-1:0] pre;
  logic en, rstm, flag, running, armed;

  wire wr_mode  = wr_en && wr_sel == SEL_MODE;
  wire wr_tc    = wr_en && wr_sel == SEL_TC;
  wire wr_feed  = wr_en && wr_sel == SEL_FEED;
  wire feed_ok  = wr_feed && armed && wr_data[7:0] == 8'h55;
  wire reload   = feed_ok && en;
  wire tick     = running && !reload && pre == PRE_LAST;
  wire expire   = tick && cnt == CW'(1);
  wire [CW-1:0] wr_val = CW'(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc <= TC_FLOOR;
    end else if (wr_tc) begin
      tc <= (wr_val < TC_FLOOR) ? TC_FLOOR : wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      rstm <= 1'b0;
    end else if (wr_mode) begin
      en   <= running | wr_data[0];
      rstm <= wr_data[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (wr_feed) armed <= wr_data[7:0] == 8'hAA;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) running <= 1'b0;
    else if (reload) running <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else if (reload || !running) pre <= '0;
    else if (pre == PRE_LAST) pre <= '0;
    else pre <= pre + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= TC_FLOOR;
    else if (reload) cnt <= tc;
    else if (tick && cnt != '0) cnt <= cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else if (expire) flag <= 1'b1;
    else if (wr_mode && wr_data[2]) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else rst_req <= expire && rstm;
  end

  assign irq = flag && !rstm;

  always_comb begin
    case (rd_sel)
      SEL_MODE: rd_data = {29'd0, flag, rstm, en};
      SEL_TC:   rd_data = 32'(tc);
      SEL_FEED: rd_data = 32'd0;
      SEL_CNT:  rd_data = 32'(cnt);
      default:  rd_data = 32'd0;
    endcase
  end
endmodule

// File: rtl/tick_watchdog_chk.sv
module tick_watchdog_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [31:0]   wr_data,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] tc,
  input logic          en,
  input logic          rstm,
  input logic          flag,
  input logic          running,
  input logic          irq,
  input logic          rst_req
);
  wire feed_w  = wr_en && wr_sel == 2'd2;
  wire clear_w = wr_en && wr_sel == 2'd0 && wr_data[2];

  p_tc_floor_r2: assert property (@(posedge clk) disable iff (!rst_n) tc >= CW'('hFF));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !feed_w |=> (cnt == $past(cnt)) || (cnt == $past(cnt) - CW'(1)));

  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !feed_w |=> $stable(cnt));

  p_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    running && en |=> en);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clear_w |=> flag);

  p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == '0 && !feed_w |=> cnt == '0);

  p_irq_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !rstm);

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  p_pulse_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> cnt == '0 && flag);
endmodule

bind tick_watchdog tick_watchdog_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .cnt(cnt), .tc(tc), .en(en), .rstm(rstm), .flag(flag), .running(running),
  .irq(irq), .rst_req(rst_req)
);

// File: tb/test_tick_watchdog.sv
module test_tick_watchdog;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] wr_sel = 0, rd_sel = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic irq, rst_req;

  tick_watchdog i_tick_watchdog (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0, feed_cyc = 0, pulses = 0, pulse_el = -1;
  logic [31:0] tc_m = 32'hFF, loaded = 32'hFF;
  bit en_m = 0, rstm_m = 0, armed_m = 0, started = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && rst_req) begin pulses++; pulse_el = cyc - feed_cyc; end

  function automatic logic [31:0] clamp(input logic [31:0] v);
    return (v < 32'hFF) ? 32'hFF : v;
  endfunction

  function automatic logic [31:0] exp_cnt(input int el);
    if (!started) return loaded;
    if (32'(el / 4) >= loaded) return 0;
    return loaded - 32'(el / 4);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    rd_sel = s; #1; v = rd_data;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
    case (s)
      2'd0: begin en_m = started ? 1'b1 : d[0]; rstm_m = d[1]; end
      2'd1: tc_m = clamp(d);
      2'd2: begin
        if (armed_m && d[7:0] == 8'h55 && en_m) begin
          loaded = tc_m; feed_cyc = cyc; started = 1;
        end
        armed_m = (d[7:0] == 8'hAA);
      end
      default: ;
    endcase
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic feed();
    wr(2'd2, 32'hAA); wr(2'd2, 32'h55);
  endtask

  task automatic chk_cnt(input string req);
    logic [31:0] v;
    rd(2'd3, v);
    check(req, v, exp_cnt(cyc - feed_cyc));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    idle(3); rst_n = 1; idle(2);

    rd(2'd3, v); check("R1 cnt", v, 32'hFF);
    rd(2'd1, v); check("R1 tc", v, 32'hFF);
    rd(2'd0, v); check("R1 mode", v, 32'h0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 rst_req", {31'd0, rst_req}, 0);

    wr(2'd1, 32'h10);    rd(2'd1, v); check("R2 small", v, 32'hFF);
    wr(2'd1, 32'h1234);  rd(2'd1, v); check("R2 large", v, 32'h1234);
    wr(2'd1, 32'hFE);    rd(2'd1, v); check("R2 below", v, 32'hFF);
    wr(2'd1, 32'h100);   rd(2'd1, v); check("R2 pass", v, 32'h100);
    wr(2'd3, 32'h5);     rd(2'd3, v); check("R1 value ro", v, 32'hFF);

    feed(); idle(40);
    rd(2'd3, v); check("R3 disabled feed", v, 32'hFF);

    wr(2'd0, 32'h1); feed();
    rd(2'd3, v); check("R4 load", v, 32'h100);
    idle(3); rd(2'd3, v); check("R4 before tick", v, 32'h100);
    idle(1); rd(2'd3, v); check("R4 first tick", v, 32'hFF);
    idle(41); chk_cnt("R4 run");

    wr(2'd2, 32'hAA); wr(2'd2, 32'h12); wr(2'd2, 32'h55);
    chk_cnt("R5 broken");
    wr(2'd2, 32'h55); chk_cnt("R5 lone 55");
    idle(7); chk_cnt("R5 later");

    wr(2'd0, 32'h0); rd(2'd0, v); check("R6 lock", v & 32'h1, 32'h1);

    wr(2'd1, 32'h120); idle(9); chk_cnt("R10 old count");
    feed(); rd(2'd3, v); check("R10 new load", v, 32'h120);

    idle(4 * 32'h120 + 12);
    rd(2'd3, v); check("R7 zero hold", v, 32'h0);
    rd(2'd0, v); check("R7 flag", v & 32'h4, 32'h4);
    check("R7 irq", {31'd0, irq}, 1);
    check("R7 no reset", pulses, 0);

    wr(2'd0, 32'h5); rd(2'd0, v); check("R9 clear", v & 32'h4, 32'h0);
    check("R9 irq low", {31'd0, irq}, 0);

    for (int i = 0; i < 40; i++) begin
      int act = $urandom_range(0, 3);
      case (act)
        0: begin wr(2'd1, $urandom_range(0, 600)); feed(); end
        1: begin wr(2'd2, 32'hAA); wr(2'd2, $urandom_range(0, 8'h54)); wr(2'd2, 32'h55); end
        2: feed();
        default: ;
      endcase
      idle($urandom_range(0, 300));
      chk_cnt(act == 1 ? "R5 random" : "R4 random");
    end

    wr(2'd0, 32'h7); wr(2'd1, 32'h0); feed();
    pulses = 0; pulse_el = -1;
    idle(4 * 255 + 40);
    check("R8 pulse count", pulses, 1);
    check("R8 pulse edge", pulse_el, 4 * 255);
    check("R8 irq low", {31'd0, irq}, 0);
    rd(2'd0, v); check("R8 flag", v & 32'h4, 32'h4);
    rd(2'd3, v); check("R8 zero", v, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule